// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the addressing fields of one instruction into a 16-bit effective address for a small 8-bit-accumulator processor. Each request carries a mode code, the program counter of the opcode, the one or two operand bytes that follow the opcode, and the current values of the X, Y and stack-pointer registers. The unit works out the address the instruction will touch. For indexed forms that adjust their pointer, it also returns the new pointer value and which register must take it.

Indexed requests take their first operand byte as a packed selector. Two bits pick the base register. One bit picks between a signed constant offset and an automatic step. For a step, one bit chooses whether the step is applied before or after the address is formed, and four bits give a step size of one to eight in either direction. The arithmetic is purely combinational. It is captured in a single output register.

Both edges of the block are valid/ready streams. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is presented the next cycle with `out_valid` high. `in_ready` is high whenever the output register is empty or its content is leaving in that same cycle, so back-to-back requests flow at one per cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is taken.

Top module: `eagu_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted on one edge appears at the outputs with `out_valid` = 1 after the next edge, and results leave in acceptance order.
- R2: While `out_valid` = 1 and `out_ready` = 0, every output stays unchanged on the next cycle and `in_ready` is 0.
- R3: Mode codes are 0 inherent, 1 immediate, 2 direct, 3 extended and 4 indexed. Inherent yields `out_ea_valid` = 0, `out_err` = 0 and no write-back. Any output field that has no meaning for a result (address, write-back select or value) reads 0.
- R4: Immediate mode gives the address PC+1 with `out_ea_valid` = 1.
- R5: Direct mode gives {8'h00, first operand byte}.
- R6: Extended mode gives {first operand byte, second operand byte}.
- R7: In indexed mode the first operand byte is a postbyte. Bits 7:6 pick the base: 0 X, 1 Y, 2 SP, 3 PC, where the PC base is PC+2. With bit 5 = 0, bits 4:0 form a signed offset that is added to the base, and no write-back occurs.
- R8: With bit 5 = 1 and bit 4 = 0 (pre form), the adjusted base is both the address and the write-back value. `out_wb_en` = 1 and `out_wb_sel` equals bits 7:6.
- R9: With bit 5 = 1 and bit 4 = 1 (post form), the address is the unadjusted base, while the adjusted value is written back. Bits 3:0 = n give a step of +(n+1) for n = 0..7 and n-16 for n = 8..15.
- R10: An automatic step with the PC as base sets `out_err` = 1, `out_ea_valid` = 0 and `out_wb_en` = 0.
- R11: All address and write-back arithmetic wraps modulo 2^16.
- R12: Mode codes 5 to 7 set `out_err` = 1 with `out_ea_valid` = 0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 3 | Addressing mode code |
| in_pc | input | 16 | Address of the opcode |
| in_op1 | input | 8 | First byte after the opcode (postbyte in indexed mode) |
| in_op2 | input | 8 | Second byte after the opcode |
| in_x | input | 16 | X register value |
| in_y | input | 16 | Y register value |
| in_sp | input | 16 | Stack pointer value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 16 | Effective address |
| out_ea_valid | output | 1 | Effective address is meaningful |
| out_wb_en | output | 1 | Base register must be updated |
| out_wb_sel | output | 2 | Register to update: 0 X, 1 Y, 2 SP |
| out_wb_value | output | 16 | New value of that register |
| out_err | output | 1 | Illegal request |

## Verification
On every cycle the assertions check the stream rules: a result cannot appear without an accepted request, and a stalled result must stay frozen. They also check that an error result never carries a write-back or a valid address, and that each accepted immediate, extended, inherent or post-step request produces the matching address one cycle later. The bench scenarios must show the rest. These are the full decode of the postbyte over every base register and step size, wraparound at the ends of the address space, the distinction between PC-relative constant offsets and the illegal PC step, and ordering under random back-pressure.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_IMM = 3'd1,
    MODE_DIR = 3'd2,
    MODE_EXT = 3'd3,
    MODE_IDX = 3'd4
  } ea_mode_e;

  typedef enum logic [1:0] {
    BASE_X  = 2'd0,
    BASE_Y  = 2'd1,
    BASE_SP = 2'd2,
    BASE_PC = 2'd3
  } base_sel_e;

  localparam int unsigned BASE_CNT = 4;

endpackage

// File: rtl/eagu_idx_decode.sv
module eagu_idx_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PB_W   = 8
) (
  input  logic [PB_W-1:0]   postbyte,
  output logic [1:0]        base_sel,
  output logic              is_auto,
  output logic              is_post,
  output logic [ADDR_W-1:0] offset
);
  localparam int unsigned OFS_W  = PB_W - 3;
  localparam int unsigned STEP_W = PB_W - 4;

  logic [OFS_W-1:0]  const_field;
  logic [STEP_W-1:0] step_field;
  logic [ADDR_W-1:0] const_ext;
  logic [ADDR_W-1:0] step_ext;

  assign base_sel    = postbyte[PB_W-1 -: 2];
  assign is_auto     = postbyte[PB_W-3];
  assign is_post     = postbyte[PB_W-4];
  assign const_field = postbyte[OFS_W-1:0];
  assign step_field  = postbyte[STEP_W-1:0];

  // constant form: signed offset, sign-extended to the address width
  assign const_ext = {{(ADDR_W-OFS_W){const_field[OFS_W-1]}}, const_field};

  // step form: upper half of the field code counts down, lower half counts up by code+1
  always_comb begin
    if (step_field[STEP_W-1]) begin
      step_ext = {{(ADDR_W-STEP_W){1'b1}}, step_field};
    end else begin
      step_ext = {{(ADDR_W-STEP_W){1'b0}}, step_field} + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end

  assign offset = is_auto ? step_ext : const_ext;

endmodule

// File: rtl/eagu_ea_calc.sv
module eagu_ea_calc
  import eagu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  input  logic [ADDR_W-1:0] reg_x,
  input  logic [ADDR_W-1:0] reg_y,
  input  logic [ADDR_W-1:0] reg_sp,
  output logic [ADDR_W-1:0] ea,
  output logic              ea_valid,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_value,
  output logic              err
);
  localparam logic [ADDR_W-1:0] IMM_BIAS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_BIAS = ADDR_W'(2);

  logic [1:0]        base_sel;
  logic              is_auto;
  logic              is_post;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] bank [BASE_CNT];
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] adjusted;

  eagu_idx_decode #(
    .ADDR_W (ADDR_W),
    .PB_W   (BYTE_W)
  ) u_decode (
    .postbyte (op1),
    .base_sel (base_sel),
    .is_auto  (is_auto),
    .is_post  (is_post),
    .offset   (offset)
  );

  for (genvar g = 0; g < BASE_CNT; g++) begin : g_bank
    if (g == int'(BASE_X)) begin : g_x
      assign bank[g] = reg_x;
    end else if (g == int'(BASE_Y)) begin : g_y
      assign bank[g] = reg_y;
    end else if (g == int'(BASE_SP)) begin : g_sp
      assign bank[g] = reg_sp;
    end else begin : g_pc
      assign bank[g] = pc + IDX_BIAS;
    end
  end

  assign base     = bank[base_sel];
  assign adjusted = base + offset;

  always_comb begin
    ea       = '0;
    ea_valid = 1'b0;
    wb_en    = 1'b0;
    wb_sel   = '0;
    wb_value = '0;
    err      = 1'b0;
    case (mode)
      MODE_INH: begin
      end
      MODE_IMM: begin
        ea       = pc + IMM_BIAS;
        ea_valid = 1'b1;
      end
      MODE_DIR: begin
        ea       = {{(ADDR_W-BYTE_W){1'b0}}, op1};
        ea_valid = 1'b1;
      end
      MODE_EXT: begin
        ea       = {op1, op2};
        ea_valid = 1'b1;
      end
      MODE_IDX: begin
        if (!is_auto) begin
          ea       = adjusted;
          ea_valid = 1'b1;
        end else if (base_sel == BASE_PC) begin
          err = 1'b1;
        end else begin
          ea       = is_post ? base : adjusted;
          ea_valid = 1'b1;
          wb_en    = 1'b1;
          wb_sel   = base_sel;
          wb_value = adjusted;
        end
      end
      default: begin
        err = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/eagu_out_reg.sv
module eagu_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2: stalled result frozen
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1: a result only follows an accepted request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [BYTE_W-1:0] in_op1,
  input  logic [BYTE_W-1:0] in_op2,
  input  logic [ADDR_W-1:0] in_x,
  input  logic [ADDR_W-1:0] in_y,
  input  logic [ADDR_W-1:0] in_sp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_ea,
  output logic              out_ea_valid,
  output logic              out_wb_en,
  output logic [1:0]        out_wb_sel,
  output logic [ADDR_W-1:0] out_wb_value,
  output logic              out_err
);
  localparam int unsigned RES_W = 2*ADDR_W + 5;

  logic [ADDR_W-1:0] c_ea;
  logic              c_ea_valid;
  logic              c_wb_en;
  logic [1:0]        c_wb_sel;
  logic [ADDR_W-1:0] c_wb_value;
  logic              c_err;
  logic [RES_W-1:0]  c_pack;
  logic [RES_W-1:0]  r_pack;

  eagu_ea_calc #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_calc (
    .mode     (in_mode),
    .pc       (in_pc),
    .op1      (in_op1),
    .op2      (in_op2),
    .reg_x    (in_x),
    .reg_y    (in_y),
    .reg_sp   (in_sp),
    .ea       (c_ea),
    .ea_valid (c_ea_valid),
    .wb_en    (c_wb_en),
    .wb_sel   (c_wb_sel),
    .wb_value (c_wb_value),
    .err      (c_err)
  );

  assign c_pack = {c_ea, c_ea_valid, c_wb_en, c_wb_sel, c_wb_value, c_err};

  eagu_out_reg #(
    .DATA_W (RES_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (c_pack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (r_pack)
  );

  assign {out_ea, out_ea_valid, out_wb_en, out_wb_sel, out_wb_value, out_err} = r_pack;

  // R10 / R12: an error result carries no address and no write-back
  a_r10_err_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (!out_wb_en && !out_ea_valid));

  // R4: immediate address is the byte after the opcode
  a_r4_imm_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == MODE_IMM) |=>
      (out_valid && out_ea_valid && out_ea == $past(in_pc) + ADDR_W'(1)));

  // R6: extended address is the two operand bytes, high first
  a_r6_ext_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == MODE_EXT) |=>
      (out_ea == {$past(in_op1), $past(in_op2)}));

  // R3: inherent requests produce no address, no write-back and no error
  a_r3_inh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == MODE_INH) |=>
      (!out_ea_valid && !out_wb_en && !out_err && out_ea == '0));

  // R9: post-step on X returns the unadjusted X as address
  a_r9_post_x_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == MODE_IDX && in_op1[7:4] == 4'b0011) |=>
      (out_ea == $past(in_x) && out_wb_en && out_wb_sel == 2'd0));

endmodule

// File: tb/test_eagu_top.sv
module test_eagu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [15:0] in_pc = '0;
  logic [7:0]  in_op1 = '0;
  logic [7:0]  in_op2 = '0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic [15:0] in_sp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ea;
  logic        out_ea_valid;
  logic        out_wb_en;
  logic [1:0]  out_wb_sel;
  logic [15:0] out_wb_value;
  logic        out_err;

  int checks = 0;
  int failures = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    string       tag;
    logic [15:0] ea;
    logic        eav;
    logic        wbe;
    logic [1:0]  wbs;
    logic [15:0] wbv;
    logic        err;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  eagu_top i_eagu_top (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_mode (in_mode),
    .in_pc (in_pc), .in_op1 (in_op1), .in_op2 (in_op2),
    .in_x (in_x), .in_y (in_y), .in_sp (in_sp),
    .out_valid (out_valid), .out_ready (out_ready), .out_ea (out_ea),
    .out_ea_valid (out_ea_valid), .out_wb_en (out_wb_en), .out_wb_sel (out_wb_sel),
    .out_wb_value (out_wb_value), .out_err (out_err)
  );

  function automatic exp_t mk(string tag, logic [15:0] ea, logic eav, logic wbe,
                              logic [1:0] wbs, logic [15:0] wbv, logic err);
    exp_t e;
    e.tag = tag; e.ea = ea; e.eav = eav; e.wbe = wbe; e.wbs = wbs; e.wbv = wbv; e.err = err;
    return e;
  endfunction

  // reference built from the requirement text (R3-R12)
  function automatic exp_t model(logic [2:0] m, logic [15:0] pc, logic [7:0] a, logic [7:0] b,
                                 logic [15:0] x, logic [15:0] y, logic [15:0] sp);
    exp_t e;
    logic [15:0] base;
    logic [15:0] step;
    logic [15:0] nb;
    e = mk("RAND", 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
    case (m)
      3'd0: ;
      3'd1: begin e.ea = pc + 16'd1; e.eav = 1'b1; end
      3'd2: begin e.ea = {8'h00, a}; e.eav = 1'b1; end
      3'd3: begin e.ea = {a, b}; e.eav = 1'b1; end
      3'd4: begin
        case (a[7:6])
          2'd0: base = x;
          2'd1: base = y;
          2'd2: base = sp;
          default: base = pc + 16'd2;
        endcase
        if (!a[5]) begin
          e.ea = base + {{11{a[4]}}, a[4:0]}; e.eav = 1'b1;
        end else if (a[7:6] == 2'd3) begin
          e.err = 1'b1;
        end else begin
          step = (a[3:0] < 4'd8) ? 16'(a[3:0]) + 16'd1 : 16'(a[3:0]) - 16'd16;
          nb = base + step;
          e.ea = a[4] ? base : nb; e.eav = 1'b1;
          e.wbe = 1'b1; e.wbs = a[7:6]; e.wbv = nb;
        end
      end
      default: e.err = 1'b1;
    endcase
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [2:0] m, logic [15:0] pc, logic [7:0] a, logic [7:0] b,
                      logic [15:0] x, logic [15:0] y, logic [15:0] sp, exp_t e);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_pc = pc; in_op1 = a; in_op2 = b;
    in_x = x; in_y = y; in_sp = sp;
    #3;
    while (!in_ready) begin
      @(negedge clk); #3;
    end
    sb.push_back(e);
    @(posedge clk); #1;
    check("R1 latency", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
  endtask

  // back-pressure driver
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [36:0] held_val;
  always begin
    exp_t e;
    @(negedge clk); #3;
    if (rst_n) begin
      if (held && out_valid) begin
        check("R2 hold", 64'({out_ea, out_ea_valid, out_wb_en, out_wb_sel, out_wb_value, out_err}),
              64'(held_val));
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        check("R2 in_ready low", 64'(in_ready), 64'd0);
        held = 1'b1;
        held_val = {out_ea, out_ea_valid, out_wb_en, out_wb_sel, out_wb_value, out_err};
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R1 unexpected result", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          check(e.tag, 64'({out_ea, out_ea_valid, out_wb_en, out_wb_sel, out_wb_value, out_err}),
                64'({e.ea, e.eav, e.wbe, e.wbs, e.wbv, e.err}));
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        send(3'd0, 16'h2000, 8'h87, 8'h00, 16'h1, 16'h2, 16'h3, mk("R3 inherent", 16'h0, 0, 0, 2'd0, 16'h0, 0));
        send(3'd1, 16'h2000, 8'h17, 8'h00, 16'h0, 16'h0, 16'h0, mk("R4 immediate", 16'h2001, 1, 0, 2'd0, 16'h0, 0));
        send(3'd1, 16'hFFFF, 8'h17, 8'h00, 16'h0, 16'h0, 16'h0, mk("R11 imm wrap", 16'h0000, 1, 0, 2'd0, 16'h0, 0));
        send(3'd2, 16'h2000, 8'h20, 8'h99, 16'h0, 16'h0, 16'h0, mk("R5 direct", 16'h0020, 1, 0, 2'd0, 16'h0, 0));
        send(3'd3, 16'h2000, 8'h10, 8'h00, 16'h0, 16'h0, 16'h0, mk("R6 extended", 16'h1000, 1, 0, 2'd0, 16'h0, 0));
        send(3'd4, 16'h2000, 8'h00, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R7 X+0", 16'h1234, 1, 0, 2'd0, 16'h0, 0));
        send(3'd4, 16'h2000, 8'h45, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R7 Y+5", 16'h3005, 1, 0, 2'd0, 16'h0, 0));
        send(3'd4, 16'h2000, 8'h9F, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R7 SP-1", 16'h03FF, 1, 0, 2'd0, 16'h0, 0));
        send(3'd4, 16'h2000, 8'hC3, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R7 PC+2+3", 16'h2005, 1, 0, 2'd0, 16'h0, 0));
        send(3'd4, 16'h2000, 8'h3E, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R9 X post -2", 16'h1234, 1, 1, 2'd0, 16'h1232, 0));
        send(3'd4, 16'h2000, 8'h23, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R8 X pre +4", 16'h1238, 1, 1, 2'd0, 16'h1238, 0));
        send(3'd4, 16'h2000, 8'h78, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R9 Y post -8", 16'h3000, 1, 1, 2'd1, 16'h2FF8, 0));
        send(3'd4, 16'h2000, 8'hAF, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R8 SP pre -1", 16'h03FF, 1, 1, 2'd2, 16'h03FF, 0));
        send(3'd4, 16'h2000, 8'h67, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R8 Y pre +8", 16'h3008, 1, 1, 2'd1, 16'h3008, 0));
        send(3'd4, 16'h2000, 8'hF0, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R10 PC step", 16'h0, 0, 0, 2'd0, 16'h0, 1));
        send(3'd6, 16'h2000, 8'h00, 8'h00, 16'h1234, 16'h3000, 16'h0400, mk("R12 reserved", 16'h0, 0, 0, 2'd0, 16'h0, 1));
        send(3'd4, 16'h2000, 8'h23, 8'h00, 16'hFFFE, 16'h3000, 16'h0400, mk("R11 pre wrap", 16'h0002, 1, 1, 2'd0, 16'h0002, 0));
        send(3'd4, 16'h2000, 8'h58, 8'h00, 16'h1234, 16'h0003, 16'h0400, mk("R11 const wrap", 16'hFFFB, 1, 0, 2'd0, 16'h0, 0));
        bp_on = 1'b1;
        for (int i = 0; i < 300; i++) begin
          logic [2:0] m; logic [15:0] pc, x, y, sp; logic [7:0] a, b;
          m = (i % 5 == 0) ? 3'($urandom_range(7)) : 3'd4;
          pc = 16'($urandom); x = 16'($urandom); y = 16'($urandom); sp = 16'($urandom);
          a = 8'($urandom); b = 8'($urandom);
          send(m, pc, a, b, x, y, sp, model(m, pc, a, b, x, y, sp));
        end
        bp_on = 1'b0;
        repeat (10) @(negedge clk);
        check("R1 drained", 64'(sb.size()), 64'd0);
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule